// File: doc/BRIEF.md
# Flash Read Response Multiplexer

This block is the read-side data path of a parallel NOR flash that uses the AMD-style command set. A command sequencer elsewhere decides which mode the device is in: plain array read, identification (autoselect), embedded-operation status, or common-flash-interface query. This block turns each bus read strobe into one registered data word taken from the matching source. It also owns the status byte that software polls while a program or an erase is running.

The array and the query table sit outside the block. Each is reached through an address output and a data input, and each must answer in the same cycle. Array bytes are packed into a 1, 2 or 4 byte result. The byte order is fixed by a parameter. The identification words and the bus width are parameters too. The status byte changes in two ways. Reading it in status mode inverts bit 6 once per read. The sequencer's program, erase-start and erase-done events load or flip it.

Top module: `flash_rd_mux`

## Requirements
- R1: After reset, rd_valid is 0 and the status byte is 0x00, so the first status-mode read returns 0x00.
- R2: rd_valid is 1 in exactly the cycle after a cycle with rd_req high, and rd_data then holds that read's result. rd_valid is 0 after a cycle without rd_req.
- R3: In array mode (rd_mode 0), the block reads bytes A, A+1, A+2, A+3 from arr_bytes, where A is rd_addr. Byte k of arr_bytes is bits 8k+7..8k. rd_size 0 returns 1 byte, 1 returns 2 bytes, and 2 or 3 returns 4 bytes, zero-extended to 32 bits. With BIG_ENDIAN=0 byte A is the least significant byte. With BIG_ENDIAN=1 byte A is the most significant byte.
- R4: In identification mode (rd_mode 1), the word offset is rd_addr[7:0] shifted right by log2(BUS_BYTES). Offsets 0 and 1 return ID0 and ID1. Offset 2 returns 0 (sector unprotected).
- R5: In identification mode, offsets 0x0E and 0x0F return ID2 and ID3, unless that word is all ones; in that case, and at every other offset, array data is returned as in R3.
- R6: In status mode (rd_mode 2), a read returns the status byte zero-extended, and the status byte's bit 6 is inverted once for each such read.
- R7: erase_start clears the status byte to 0x00. erase_done inverts status bit 7. erase_done combines with a same-cycle status read, so both bit 6 and bit 7 flip.
- R8: prog_evt loads the status byte with bit 7 equal to the inverse of prog_data bit 7 and bits 6..0 all ones.
- R9: In query mode (rd_mode 3), cfi_idx carries the word offset of R4. The read returns cfi_byte when the offset is below CFI_LEN, and 0 when it is not.
- R10: Reads in any mode other than status leave the status byte unchanged. When erase_start or prog_evt coincides with a status read, the read returns the old byte and the loaded value is kept without a bit 6 toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | One-cycle read strobe |
| rd_mode | input | 2 | Mode from sequencer: 0 array, 1 ident, 2 status, 3 query |
| rd_size | input | 2 | Access size: 0 byte, 1 half, 2/3 word |
| rd_addr | input | ADDR_W | Byte address of the read |
| arr_addr | output | ADDR_W | Address of the first array byte requested |
| arr_bytes | input | 32 | Array bytes at arr_addr..arr_addr+3, same cycle |
| cfi_idx | output | 8 | Query table offset |
| cfi_byte | input | 8 | Query table byte at cfi_idx, same cycle |
| prog_evt | input | 1 | Program accepted, load status from prog_data |
| prog_data | input | 8 | Low byte of programmed data |
| erase_start | input | 1 | Erase started, clear status |
| erase_done | input | 1 | Erase finished, flip status bit 7 |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |

## Verification
The bench builds two copies with a 2-byte bus width and CFI_LEN 0x40. One copy is little-endian and one is big-endian, so the byte-order variants are checked from the same stimulus. ID3 is set to all ones while ID2 is not, which makes both the identification word and the array fallback reachable at offsets 0x0E and 0x0F. The small table length puts the zero return at offset 0x40 inside an 8-bit offset range. The status byte is followed through its loads, its flips and same-cycle collisions of events with status reads.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

   localparam int RD_DATA_W = 32;
   localparam int BYTE_W    = 8;

   typedef enum logic [1:0] {
      MODE_ARRAY  = 2'd0,
      MODE_IDENT  = 2'd1,
      MODE_STATUS = 2'd2,
      MODE_QUERY  = 2'd3
   } rd_mode_e;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_WORD2 = 2'd3
   } rd_size_e;

   // status byte after a program: inverted data bit 7, remaining bits set
   function automatic logic [7:0] prog_status(input logic [7:0] d);
      return {~d[7], 7'h7F};
   endfunction

endpackage

// File: rtl/flash_rd_array_fmt.sv
module flash_rd_array_fmt
   import flash_rd_pkg::*;
#(
   parameter bit BIG_ENDIAN = 1'b0
)(
   input  logic [1:0]           size,
   input  logic [31:0]          bytes_in,
   output logic [RD_DATA_W-1:0] word
);

   logic [7:0] b0, b1, b2, b3;

   assign b0 = bytes_in[7:0];
   assign b1 = bytes_in[15:8];
   assign b2 = bytes_in[23:16];
   assign b3 = bytes_in[31:24];

   generate
      if (BIG_ENDIAN) begin : g_be
         always_comb begin
            unique case (rd_size_e'(size))
               SZ_BYTE: word = {24'h0, b0};
               SZ_HALF: word = {16'h0, b0, b1};
               default: word = {b0, b1, b2, b3};
            endcase
         end
      end else begin : g_le
         always_comb begin
            unique case (rd_size_e'(size))
               SZ_BYTE: word = {24'h0, b0};
               SZ_HALF: word = {16'h0, b1, b0};
               default: word = {b3, b2, b1, b0};
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/flash_rd_id_sel.sv
module flash_rd_id_sel
   import flash_rd_pkg::*;
#(
   parameter int            ID_W = 16,
   parameter logic [ID_W-1:0] ID0 = '0,
   parameter logic [ID_W-1:0] ID1 = '0,
   parameter logic [ID_W-1:0] ID2 = '1,
   parameter logic [ID_W-1:0] ID3 = '1
)(
   input  logic [7:0]           woff,
   input  logic [RD_DATA_W-1:0] arr_word,
   output logic [RD_DATA_W-1:0] word
);

   localparam logic [ID_W-1:0] UNSET = '1;
   localparam bit ID2_SET = (ID2 != UNSET);
   localparam bit ID3_SET = (ID3 != UNSET);

   generate
      if (ID_W > RD_DATA_W) begin : g_bad_w
         $error("flash_rd_id_sel: ID_W wider than read data");
      end
   endgenerate

   always_comb begin
      word = arr_word;
      unique case (woff)
         8'h00: word = RD_DATA_W'(ID0);
         8'h01: word = RD_DATA_W'(ID1);
         8'h02: word = '0;
         8'h0E: if (ID2_SET) word = RD_DATA_W'(ID2);
         8'h0F: if (ID3_SET) word = RD_DATA_W'(ID3);
         default: word = arr_word;
      endcase
   end

endmodule

// File: rtl/flash_rd_status.sv
module flash_rd_status
   import flash_rd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_stat,
   input  logic       prog_evt,
   input  logic [7:0] prog_data,
   input  logic       erase_start,
   input  logic       erase_done,
   output logic [7:0] status
);

   logic [7:0] status_q;
   logic [7:0] status_d;
   logic       load_any;

   assign load_any = erase_start | prog_evt;

   always_comb begin
      status_d = status_q;
      if (erase_start) begin
         status_d = 8'h00;
      end else if (prog_evt) begin
         status_d = prog_status(prog_data);
      end else begin
         if (erase_done) status_d[7] = ~status_q[7];
         if (rd_stat)    status_d[6] = ~status_q[6];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) status_q <= 8'h00;
      else        status_q <= status_d;
   end

   assign status = status_q;

   p_toggle_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !load_any && !erase_done) |=> status_q == ($past(status_q) ^ 8'h40));

   p_erase_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      erase_start |=> status_q == 8'h00);

   p_done_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_done && !load_any && !rd_stat) |=> status_q == ($past(status_q) ^ 8'h80));

   p_prog_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_evt && !erase_start) |=> status_q[6:0] == 7'h7F);

   p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_stat && !load_any && !erase_done) |=> $stable(status_q));

endmodule

// File: rtl/flash_rd_mux.sv
module flash_rd_mux
   import flash_rd_pkg::*;
#(
   parameter int              ADDR_W     = 16,
   parameter int              BUS_BYTES  = 2,
   parameter bit              BIG_ENDIAN = 1'b0,
   parameter int              CFI_LEN    = 82,
   parameter int              ID_W       = 16,
   parameter logic [ID_W-1:0] ID0        = 16'h0001,
   parameter logic [ID_W-1:0] ID1        = 16'h0022,
   parameter logic [ID_W-1:0] ID2        = '1,
   parameter logic [ID_W-1:0] ID3        = '1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd_req,
   input  logic [1:0]           rd_mode,
   input  logic [1:0]           rd_size,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [ADDR_W-1:0]    arr_addr,
   input  logic [31:0]          arr_bytes,
   output logic [7:0]           cfi_idx,
   input  logic [7:0]           cfi_byte,
   input  logic                 prog_evt,
   input  logic [7:0]           prog_data,
   input  logic                 erase_start,
   input  logic                 erase_done,
   output logic                 rd_valid,
   output logic [RD_DATA_W-1:0] rd_data
);

   localparam int OFF_SHIFT = $clog2(BUS_BYTES);
   localparam logic [8:0] CFI_LIM = 9'(CFI_LEN);

   generate
      if (BUS_BYTES != 1 && BUS_BYTES != 2 && BUS_BYTES != 4) begin : g_bad_bus
         $error("flash_rd_mux: BUS_BYTES must be 1, 2 or 4");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("flash_rd_mux: ADDR_W must be at least 8");
      end
      if (CFI_LEN < 1 || CFI_LEN > 256) begin : g_bad_cfi
         $error("flash_rd_mux: CFI_LEN must be 1..256");
      end
   endgenerate

   rd_mode_e             mode;
   logic [7:0]           woff;
   logic [RD_DATA_W-1:0] arr_word;
   logic [RD_DATA_W-1:0] id_word;
   logic [RD_DATA_W-1:0] rd_nxt;
   logic [7:0]           status;
   logic                 rd_stat;
   logic                 cfi_hit;
   logic                 valid_q;
   logic [RD_DATA_W-1:0] data_q;

   assign mode = rd_mode_e'(rd_mode);

   // word offset within the low address byte, scaled by the bus width
   generate
      if (OFF_SHIFT == 0) begin : g_off_b
         assign woff = rd_addr[7:0];
      end else begin : g_off_w
         assign woff = {{OFF_SHIFT{1'b0}}, rd_addr[7:OFF_SHIFT]};
      end
   endgenerate

   assign arr_addr = rd_addr;
   assign cfi_idx  = woff;
   assign cfi_hit  = {1'b0, woff} < CFI_LIM;
   assign rd_stat  = rd_req && (mode == MODE_STATUS);

   flash_rd_array_fmt #(.BIG_ENDIAN(BIG_ENDIAN)) u_fmt (
      .size     (rd_size),
      .bytes_in (arr_bytes),
      .word     (arr_word)
   );

   flash_rd_id_sel #(
      .ID_W (ID_W),
      .ID0  (ID0),
      .ID1  (ID1),
      .ID2  (ID2),
      .ID3  (ID3)
   ) u_id (
      .woff     (woff),
      .arr_word (arr_word),
      .word     (id_word)
   );

   flash_rd_status u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_stat     (rd_stat),
      .prog_evt    (prog_evt),
      .prog_data   (prog_data),
      .erase_start (erase_start),
      .erase_done  (erase_done),
      .status      (status)
   );

   always_comb begin
      unique case (mode)
         MODE_ARRAY:  rd_nxt = arr_word;
         MODE_IDENT:  rd_nxt = id_word;
         MODE_STATUS: rd_nxt = {24'h0, status};
         MODE_QUERY:  rd_nxt = cfi_hit ? {24'h0, cfi_byte} : '0;
         default:     rd_nxt = arr_word;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else begin
         valid_q <= rd_req;
         if (rd_req) data_q <= rd_nxt;
      end
   end

   assign rd_valid = valid_q;
   assign rd_data  = data_q;

   p_valid_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);

   p_no_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid);

   p_id_unprot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && mode == MODE_IDENT && woff == 8'h02) |=> rd_data == '0);

   p_cfi_beyond_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && mode == MODE_QUERY && !cfi_hit) |=> rd_data == '0);

   p_stat_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && mode == MODE_STATUS) |=> rd_data[31:8] == 24'h0);

endmodule

// File: tb/flash_rd_mux_bench.sv
module flash_rd_mux_bench;

   localparam int ADDR_W = 16;
   localparam logic [15:0] ID0 = 16'h0001;
   localparam logic [15:0] ID1 = 16'h22A7;
   localparam logic [15:0] ID2 = 16'h2210;
   localparam logic [15:0] ID3 = 16'hFFFF;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rd_req = 1'b0;
   logic [1:0]        rd_mode = 2'd0;
   logic [1:0]        rd_size = 2'd0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [ADDR_W-1:0] arr_addr, arr_addr_b;
   logic [31:0]       arr_bytes;
   logic [7:0]        cfi_idx, cfi_idx_b, cfi_byte;
   logic              prog_evt = 1'b0;
   logic [7:0]        prog_data = 8'h00;
   logic              erase_start = 1'b0;
   logic              erase_done = 1'b0;
   logic              rd_valid, rd_valid_b;
   logic [31:0]       rd_data, rd_data_b;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [7:0] es = 8'h00;

   always #5 clk = ~clk;

   function automatic logic [7:0] mb(input logic [ADDR_W-1:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   assign arr_bytes = {mb(arr_addr + 16'd3), mb(arr_addr + 16'd2),
                       mb(arr_addr + 16'd1), mb(arr_addr)};
   assign cfi_byte  = cfi_idx ^ 8'hC3;

   flash_rd_mux #(.ADDR_W(ADDR_W), .BUS_BYTES(2), .BIG_ENDIAN(1'b0), .CFI_LEN(64),
                  .ID_W(16), .ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3)) u_flash_rd_mux (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_mode(rd_mode), .rd_size(rd_size),
      .rd_addr(rd_addr), .arr_addr(arr_addr), .arr_bytes(arr_bytes), .cfi_idx(cfi_idx),
      .cfi_byte(cfi_byte), .prog_evt(prog_evt), .prog_data(prog_data),
      .erase_start(erase_start), .erase_done(erase_done), .rd_valid(rd_valid),
      .rd_data(rd_data));

   flash_rd_mux #(.ADDR_W(ADDR_W), .BUS_BYTES(2), .BIG_ENDIAN(1'b1), .CFI_LEN(64),
                  .ID_W(16), .ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3)) u_flash_rd_mux_be (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_mode(rd_mode), .rd_size(rd_size),
      .rd_addr(rd_addr), .arr_addr(arr_addr_b), .arr_bytes(arr_bytes), .cfi_idx(cfi_idx_b),
      .cfi_byte(cfi_byte), .prog_evt(prog_evt), .prog_data(prog_data),
      .erase_start(erase_start), .erase_done(erase_done), .rd_valid(rd_valid_b),
      .rd_data(rd_data_b));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // one read; optional same-cycle status events; returns both copies' data
   task automatic do_read(input logic [1:0] mode, input logic [1:0] size,
                          input logic [15:0] addr, input bit ev_start, input bit ev_done,
                          input bit ev_prog, input logic [7:0] pdata,
                          output logic [31:0] d_le, output logic [31:0] d_be);
      @(negedge clk);
      rd_req = 1'b1; rd_mode = mode; rd_size = size; rd_addr = addr;
      erase_start = ev_start; erase_done = ev_done; prog_evt = ev_prog; prog_data = pdata;
      @(negedge clk);
      rd_req = 1'b0; erase_start = 1'b0; erase_done = 1'b0; prog_evt = 1'b0;
      check("R2 valid after strobe", {31'h0, rd_valid}, 32'h1);
      check("R2 valid after strobe be", {31'h0, rd_valid_b}, 32'h1);
      d_le = rd_data;
      d_be = rd_data_b;
   endtask

   task automatic pulse(input bit ev_start, input bit ev_done, input bit ev_prog,
                        input logic [7:0] pdata);
      @(negedge clk);
      erase_start = ev_start; erase_done = ev_done; prog_evt = ev_prog; prog_data = pdata;
      @(negedge clk);
      erase_start = 1'b0; erase_done = 1'b0; prog_evt = 1'b0;
      check("R2 no valid without strobe", {31'h0, rd_valid}, 32'h0);
   endtask

   task automatic stat_read(input string req);
      logic [31:0] a, b;
      do_read(2'd2, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, a, b);
      check(req, a, {24'h0, es});
      es = es ^ 8'h40;
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1 rd_valid after reset", {31'h0, rd_valid}, 32'h0);
      stat_read("R1 status after reset");
   endtask

   task automatic t_array;
      logic [31:0] a, b;
      do_read(2'd0, 2'd2, 16'h0124, 1'b0, 1'b0, 1'b0, 8'h00, a, b);
      check("R3 word le", a, {mb(16'h0127), mb(16'h0126), mb(16'h0125), mb(16'h0124)});
      check("R3 word be", b, {mb(16'h0124), mb(16'h0125), mb(16'h0126), mb(16'h0127)});
      do_read(2'd0, 2'd1, 16'h3A51, 1'b0, 1'b0, 1'b0, 8'h00, a, b);
      check("R3 half le", a, {16'h0, mb(16'h3A52), mb(16'h3A51)});
      check("R3 half be", b, {16'h0, mb(16'h3A51), mb(16'h3A52)});
      do_read(2'd0, 2'd0, 16'h7F03, 1'b0, 1'b0, 1'b0, 8'h00, a, b);
      check("R3 byte le", a, {24'h0, mb(16'h7F03)});
      check("R3 byte be", b, {24'h0, mb(16'h7F03)});
      do_read(2'd0, 2'd3, 16'h0010, 1'b0, 1'b0, 1'b0, 8'h00, a, b);
      check("R3 size 3 as word", a, {mb(16'h0013), mb(16'h0012), mb(16'h0011), mb(16'h0010)});
   endtask

   task automatic t_ident;
      logic [31:0] a, b;
      do_read(2'd1, 2'd1, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, a, b);
      check("R4 id0", a, {16'h0, ID0});
      do_read(2'd1, 2'd1, 16'h0302, 1'b0, 1'b0, 1'b0, 8'h00, a, b);
      check("R4 id1 upper addr ignored", a, {16'h0, ID1});
      do_read(2'd1, 2'd1, 16'h0004, 1'b0, 1'b0, 1'b0, 8'h00, a, b);
      check("R4 unprotected", a, 32'h0);
      do_read(2'd1, 2'd1, 16'h001C, 1'b0, 1'b0, 1'b0, 8'h00, a, b);
      check("R5 id2 set", a, {16'h0, ID2});
      do_read(2'd1, 2'd1, 16'h001E, 1'b0, 1'b0, 1'b0, 8'h00, a, b);
      check("R5 id3 unset falls back le", a, {16'h0, mb(16'h001F), mb(16'h001E)});
      check("R5 id3 unset falls back be", b, {16'h0, mb(16'h001E), mb(16'h001F)});
      do_read(2'd1, 2'd1, 16'h000A, 1'b0, 1'b0, 1'b0, 8'h00, a, b);
      check("R5 other offset array", a, {16'h0, mb(16'h000B), mb(16'h000A)});
   endtask

   task automatic t_query;
      logic [31:0] a, b;
      do_read(2'd3, 2'd0, 16'h0020, 1'b0, 1'b0, 1'b0, 8'h00, a, b);
      check("R9 table byte", a, {24'h0, 8'h10 ^ 8'hC3});
      do_read(2'd3, 2'd0, 16'h007E, 1'b0, 1'b0, 1'b0, 8'h00, a, b);
      check("R9 last entry", a, {24'h0, 8'h3F ^ 8'hC3});
      do_read(2'd3, 2'd0, 16'h0080, 1'b0, 1'b0, 1'b0, 8'h00, a, b);
      check("R9 beyond table", a, 32'h0);
   endtask

   task automatic t_status;
      logic [31:0] a, b;
      stat_read("R6 toggle read 1");
      stat_read("R6 toggle read 2");
      do_read(2'd0, 2'd2, 16'h0040, 1'b0, 1'b0, 1'b0, 8'h00, a, b);
      do_read(2'd3, 2'd0, 16'h0020, 1'b0, 1'b0, 1'b0, 8'h00, a, b);
      stat_read("R10 other reads leave status");
      pulse(1'b1, 1'b0, 1'b0, 8'h00); es = 8'h00;
      stat_read("R7 erase start clears");
      pulse(1'b0, 1'b1, 1'b0, 8'h00); es = es ^ 8'h80;
      stat_read("R7 erase done flips bit 7");
      pulse(1'b0, 1'b0, 1'b1, 8'h80); es = 8'h7F;
      stat_read("R8 program data bit7 set");
      pulse(1'b0, 1'b0, 1'b1, 8'h35); es = 8'hFF;
      stat_read("R8 program data bit7 clear");
      do_read(2'd2, 2'd0, 16'h0000, 1'b1, 1'b0, 1'b0, 8'h00, a, b);
      check("R10 read with erase start old value", a, {24'h0, es});
      es = 8'h00;
      stat_read("R10 load beats toggle");
      do_read(2'd2, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 8'h00, a, b);
      check("R10 read with program old value", a, {24'h0, es});
      es = 8'hFF;
      stat_read("R10 program load beats toggle");
      do_read(2'd2, 2'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 8'h00, a, b);
      check("R7 read with done", a, {24'h0, es});
      es = es ^ 8'hC0;
      stat_read("R7 done and toggle compose");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_array();
      t_ident();
      t_query();
      t_status();
      repeat (2) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule